// File: doc/BRIEF.md
# DDR3 Read-Side Bank Timing Guard

This block sits beside the command scheduler of a DDR3 memory controller. It watches every command the scheduler issues to one group of banks: activate, read, read with auto precharge, write and precharge, each with a bank number. From that history it drives, for every bank and every command kind, an "allowed this cycle" flag. The scheduler picks only commands whose flag is high. If a command arrives whose flag is low, the block raises a violation strobe and drops the command without changing any state.

The block enforces the spacing rules that follow a read:
- the read-to-read burst gap on the shared data bus;
- the read-to-write bus turnaround;
- the read-to-precharge spacing within one bank;
- the precharge-to-activate recovery;
- the internal precharge that a read with auto precharge schedules.

The internal precharge starts at the later of two limits: the read-to-precharge limit and the minimum active time since the bank was opened. The recovery count then runs from that internal event.

All timing values are inputs in clock cycles, so one instance serves any speed grade. Every count is a saturating down-counter that reaches zero exactly in the first cycle a command is legal.

Top module: `rd_timing_guard`

## Requirements
- R1: After an accepted read (op 2 or 3) in cycle c, `rd_ok` is low for every bank until cycle c+T_CCD, where it returns high for each open bank that has no pending auto precharge.
- R2: After an accepted read in cycle c, `wr_ok` is low for every bank until cycle c+max(RL+T_CCD−WL+2, 0).
- R3: After an accepted read to bank b in cycle c, `pre_ok[b]` is low until cycle c+max(AL+T_RTP, 4). `pre_ok` of the other banks is unaffected.
- R4: After an accepted precharge (op 5) to bank b in cycle p, the bank is closed: `rd_ok[b]` and `wr_ok[b]` are low, and `act_ok[b]` is low until cycle p+T_RP.
- R5: A precharge to a bank that is already closed is accepted and restarts the recovery window from that latest precharge.
- R6: A read with auto precharge (op 3) to bank b in cycle c blocks all commands to b. If the minimum active time is already met, the internal precharge happens at cycle c+max(AL+T_RTP, 4), and `act_ok[b]` rises at that cycle plus T_RP.
- R7: If the minimum active time T_RAS since the bank's activate in cycle a is not met by then, the internal precharge is held back to cycle a+T_RAS. `act_ok[b]` then rises at a+T_RAS+T_RP.
- R8: An activate (op 1) is allowed only to a closed bank whose recovery count is done. Reads and writes (op 4) are allowed only to an open bank.
- R9: `violation` is high, combinationally in the same cycle, when `cmd_op` is not 0 (no command) and the flag for that command and bank is low. Codes 6 and 7 always count as a violation. A rejected command changes no state.
- R10: After synchronous reset, all banks are closed with no pending counts. `act_ok` and `pre_ok` are all high, `rd_ok` and `wr_ok` are all low, and `violation` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 3 | Issued command: 0 none, 1 activate, 2 read, 3 read with auto precharge, 4 write, 5 precharge |
| cmd_bank | input | BW (3) | Bank number of the issued command |
| t_rl | input | TW (5) | Read latency in cycles |
| t_wl | input | TW (5) | Write latency in cycles |
| t_al | input | TW (5) | Additive latency in cycles |
| t_ccd | input | TW (5) | Column-to-column gap in cycles |
| t_rtp | input | TW (5) | Read-to-precharge time in cycles |
| t_rp | input | TW (5) | Precharge recovery time in cycles |
| t_ras | input | TW (5) | Minimum active time in cycles |
| act_ok | output | NBANK (8) | Per-bank activate allowed |
| rd_ok | output | NBANK (8) | Per-bank read allowed |
| wr_ok | output | NBANK (8) | Per-bank write allowed |
| pre_ok | output | NBANK (8) | Per-bank precharge allowed |
| violation | output | 1 | Current command is not allowed and is dropped |

## Verification
A table of one-command-per-cycle vectors drives a mixed stream across two banks. Comparing the expected violation bit against the strobe tells apart each blocking cause: a closed bank, an open bank, the burst gap, the turnaround and the read-to-precharge spacing.

Directed tests then walk each flag cycle by cycle after a single trigger. This shows that a window opens exactly at its computed edge, neither one cycle early nor one cycle late. The directed tests cover:
- additive latency settings where the floor of four dominates;
- additive latency settings where the read-to-precharge time dominates;
- an auto precharge that the minimum active time holds back;
- a second precharge that restarts recovery;
- an illegal read that must not reload the turnaround.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_RDA  = 3'd3,
    OP_WR   = 3'd4,
    OP_PRE  = 3'd5
  } op_e;

  // A span of n cycles is loaded as n-1 so that the count reads zero
  // in exactly the n-th cycle after the command.
  function automatic int span_load(int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  // Read-to-write bus turnaround span.
  function automatic int rtw_span(int rl, int ccd, int wl);
    int v;
    v = rl + ccd - wl + 2;
    return (v < 0) ? 0 : v;
  endfunction

  // Read-to-precharge span: additive latency plus tRTP, never under four.
  function automatic int rtp_span(int al, int rtp);
    int v;
    v = al + rtp;
    return (v < 4) ? 4 : v;
  endfunction

endpackage

// File: rtl/rdg_bus_turn.sv
module rdg_bus_turn #(
  parameter int CNTW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_go,
  input  logic [CNTW-1:0] rd_load,
  input  logic [CNTW-1:0] wr_load,
  output logic            rd_free,
  output logic            wr_free
);

  logic [CNTW-1:0] rd_cnt;
  logic [CNTW-1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else if (rd_go) begin
      rd_cnt <= rd_load;
      wr_cnt <= wr_load;
    end else begin
      if (rd_cnt != '0) rd_cnt <= rd_cnt - 1'b1;
      if (wr_cnt != '0) wr_cnt <= wr_cnt - 1'b1;
    end
  end

  assign rd_free = (rd_cnt == '0);
  assign wr_free = (wr_cnt == '0);

  a_r1_read_gap: assert property (@(posedge clk) disable iff (rst)
    (rd_go && rd_load != '0) |=> !rd_free);

  a_r2_turnaround: assert property (@(posedge clk) disable iff (rst)
    (rd_go && wr_load != '0) |=> !wr_free);

endmodule

// File: rtl/rdg_bank.sv
module rdg_bank #(
  parameter int CNTW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_act,
  input  logic            go_rd,
  input  logic            go_rda,
  input  logic            go_pre,
  input  logic [CNTW-1:0] ras_load,
  input  logic [CNTW-1:0] rtp_load,
  input  logic [CNTW-1:0] rp_load,
  output logic            act_ok,
  output logic            open_ok,
  output logic            pre_ok,
  output logic            ap_fire
);

  logic            active;
  logic            ap_pend;
  logic [CNTW-1:0] ras_cnt;
  logic [CNTW-1:0] rtp_cnt;
  logic [CNTW-1:0] rp_cnt;

  // Internal precharge: the later of the tRTP and tRAS limits.
  assign ap_fire = ap_pend && (rtp_cnt == '0) && (ras_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ap_pend <= 1'b0;
      ras_cnt <= '0;
      rtp_cnt <= '0;
      rp_cnt  <= '0;
    end else begin
      if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      if (rtp_cnt != '0) rtp_cnt <= rtp_cnt - 1'b1;
      if (rp_cnt  != '0) rp_cnt  <= rp_cnt  - 1'b1;
      if (go_act) begin
        active  <= 1'b1;
        ras_cnt <= ras_load;
      end
      if (go_rd || go_rda) rtp_cnt <= rtp_load;
      if (go_rda) ap_pend <= 1'b1;
      if (go_pre || ap_fire) begin
        active  <= 1'b0;
        ap_pend <= 1'b0;
        rp_cnt  <= rp_load;
      end
    end
  end

  assign act_ok  = !active && !ap_pend && (rp_cnt == '0);
  assign open_ok = active && !ap_pend;
  assign pre_ok  = !ap_pend && (!active || rtp_cnt == '0);

  a_r3_rd_to_pre: assert property (@(posedge clk) disable iff (rst)
    (go_rd && rtp_load != '0) |=> !pre_ok);

  a_r4_rp_hold: assert property (@(posedge clk) disable iff (rst)
    ((go_pre || ap_fire) && rp_load != '0) |=> !act_ok);

  a_r6_ap_blocks: assert property (@(posedge clk) disable iff (rst)
    go_rda |=> (!act_ok && !open_ok && !pre_ok));

  a_r7_ras_lockout: assert property (@(posedge clk) disable iff (rst)
    (ap_pend && ras_cnt != '0) |=> ap_pend);

endmodule

// File: rtl/rd_timing_guard.sv
module rd_timing_guard
  import rdg_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int TW    = 5,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CNTW = TW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_op,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [TW-1:0]    t_rl,
  input  logic [TW-1:0]    t_wl,
  input  logic [TW-1:0]    t_al,
  input  logic [TW-1:0]    t_ccd,
  input  logic [TW-1:0]    t_rtp,
  input  logic [TW-1:0]    t_rp,
  input  logic [TW-1:0]    t_ras,
  output logic [NBANK-1:0] act_ok,
  output logic [NBANK-1:0] rd_ok,
  output logic [NBANK-1:0] wr_ok,
  output logic [NBANK-1:0] pre_ok,
  output logic             violation
);

  op_e             op;
  logic            cmd_allowed;
  logic            accept;
  logic            rd_free;
  logic            wr_free;
  logic [NBANK-1:0] open_ok;
  logic [NBANK-1:0] ap_fire;
  logic [CNTW-1:0] rd_load, wr_load, rtp_load, rp_load, ras_load;

  assign op = op_e'(cmd_op);

  assign rd_load  = CNTW'(span_load(int'(t_ccd)));
  assign wr_load  = CNTW'(span_load(rtw_span(int'(t_rl), int'(t_ccd), int'(t_wl))));
  assign rtp_load = CNTW'(span_load(rtp_span(int'(t_al), int'(t_rtp))));
  assign rp_load  = CNTW'(span_load(int'(t_rp)));
  assign ras_load = CNTW'(span_load(int'(t_ras)));

  always_comb begin
    case (op)
      OP_NONE:       cmd_allowed = 1'b1;
      OP_ACT:        cmd_allowed = act_ok[cmd_bank];
      OP_RD, OP_RDA: cmd_allowed = rd_ok[cmd_bank];
      OP_WR:         cmd_allowed = wr_ok[cmd_bank];
      OP_PRE:        cmd_allowed = pre_ok[cmd_bank];
      default:       cmd_allowed = 1'b0;
    endcase
  end

  assign accept    = (op != OP_NONE) && cmd_allowed;
  assign violation = (op != OP_NONE) && !cmd_allowed;

  rdg_bus_turn #(.CNTW(CNTW)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .rd_go   (accept && (op == OP_RD || op == OP_RDA)),
    .rd_load (rd_load),
    .wr_load (wr_load),
    .rd_free (rd_free),
    .wr_free (wr_free)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = accept && (int'(cmd_bank) == i);
    rdg_bank #(.CNTW(CNTW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .go_act   (hit && op == OP_ACT),
      .go_rd    (hit && op == OP_RD),
      .go_rda   (hit && op == OP_RDA),
      .go_pre   (hit && op == OP_PRE),
      .ras_load (ras_load),
      .rtp_load (rtp_load),
      .rp_load  (rp_load),
      .act_ok   (act_ok[i]),
      .open_ok  (open_ok[i]),
      .pre_ok   (pre_ok[i]),
      .ap_fire  (ap_fire[i])
    );
  end

  assign rd_ok = open_ok & {NBANK{rd_free}};
  assign wr_ok = open_ok & {NBANK{wr_free}};

  a_r9_rejected_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (violation && op == OP_ACT) |=> !open_ok[$past(cmd_bank)] || $past(open_ok[cmd_bank]));

  a_r8_one_internal_pre: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ap_fire & ~open_ok) || (ap_fire == '0));

endmodule

// File: tb/sim_rd_timing_guard.sv
module sim_rd_timing_guard;

  localparam int CLK_P = 10;
  localparam int NB    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic [4:0] t_rl, t_wl, t_al, t_ccd, t_rtp, t_rp, t_ras;
  logic [NB-1:0] act_ok, rd_ok, wr_ok, pre_ok;
  logic violation;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rd_timing_guard u0 (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .t_rl(t_rl), .t_wl(t_wl), .t_al(t_al), .t_ccd(t_ccd),
    .t_rtp(t_rtp), .t_rp(t_rp), .t_ras(t_ras),
    .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok),
    .violation(violation)
  );

  // {op, bank, expected violation}; one command per cycle from reset,
  // timing RL6 WL5 AL0 CCD4 RTP4 RP5 RAS12.
  localparam logic [6:0] VEC [0:10] = '{
    {3'd2, 3'd1, 1'b1},  // read to closed bank
    {3'd1, 3'd1, 1'b0},  // open bank 1
    {3'd1, 3'd1, 1'b1},  // open an open bank
    {3'd1, 3'd2, 1'b0},  // open bank 2
    {3'd2, 3'd1, 1'b0},  // read bank 1
    {3'd2, 3'd2, 1'b1},  // burst gap
    {3'd4, 3'd1, 1'b1},  // turnaround
    {3'd5, 3'd1, 1'b1},  // read-to-precharge, 3 cycles after read
    {3'd5, 3'd1, 1'b0},  // 4 cycles after read
    {3'd2, 3'd1, 1'b1},  // closed again
    {3'd1, 3'd1, 1'b1}   // recovery not done
  };

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_timing(int rl, int wl, int al, int ccd, int rtp, int rp, int ras);
    t_rl = 5'(rl); t_wl = 5'(wl); t_al = 5'(al); t_ccd = 5'(ccd);
    t_rtp = 5'(rtp); t_rp = 5'(rp); t_ras = 5'(ras);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_op = 3'd0;
    step();
    step();
    rst = 1'b0;
  endtask

  // Drive one command for one cycle; optionally check the strobe.
  task automatic issue(int op, int b, int expv, string tag);
    cmd_op = 3'(op);
    cmd_bank = 3'(b);
    #1;
    if (expv >= 0) check(tag, int'(violation), expv);
    step();
    cmd_op = 3'd0;
  endtask

  function automatic logic flag(int kind, int b);
    case (kind)
      0: return act_ok[b];
      1: return rd_ok[b];
      2: return wr_ok[b];
      default: return pre_ok[b];
    endcase
  endfunction

  // Called at cycle c+k0 after a trigger at c; checks every cycle up to c+n.
  task automatic gap_check(int kind, int b, int n, int k0, string tag);
    for (int k = k0; k <= n; k++) begin
      #1;
      check($sformatf("%s k=%0d", tag, k), int'(flag(kind, b)), (k >= n) ? 1 : 0);
      if (k < n) step();
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    set_timing(6, 5, 0, 4, 4, 5, 12);
    @(negedge clk);
    do_reset();

    // R10 reset state
    #1;
    check("R10 act_ok", int'(act_ok), 8'hFF);
    check("R10 pre_ok", int'(pre_ok), 8'hFF);
    check("R10 rd_ok", int'(rd_ok), 0);
    check("R10 wr_ok", int'(wr_ok), 0);
    check("R10 violation", int'(violation), 0);

    // R9 vector table: R8 closed/open, R1 burst, R2 turn, R3 spacing, R4 recovery
    for (int i = 0; i <= 10; i++)
      issue(int'(VEC[i][6:4]), int'(VEC[i][3:1]), int'(VEC[i][0]),
            $sformatf("R9 vector %0d", i));

    // R1 read-to-read gap
    do_reset();
    issue(1, 0, 0, "R8 activate");
    issue(2, 0, 0, "R1 read");
    gap_check(1, 0, 4, 1, "R1 rd_ok");

    // R2 read-to-write gap: 6+4-5+2 = 7
    do_reset();
    issue(1, 0, 0, "R8 activate");
    issue(2, 0, 0, "R2 read");
    gap_check(2, 0, 7, 1, "R2 wr_ok");

    // R3 read-to-precharge, floor of four dominates (AL2+RTP1)
    set_timing(6, 5, 2, 4, 1, 5, 12);
    do_reset();
    issue(1, 3, 0, "R8 activate b3");
    issue(1, 0, 0, "R8 activate b0");
    issue(2, 0, 0, "R3 read");
    #1;
    check("R3 other bank pre_ok", int'(pre_ok[3]), 1);
    gap_check(3, 0, 4, 1, "R3 pre_ok floor");

    // R4 precharge-to-activate and closed bank
    set_timing(6, 5, 0, 4, 4, 5, 12);
    do_reset();
    issue(1, 0, 0, "R8 activate");
    issue(5, 0, 0, "R4 precharge");
    #1;
    check("R4 rd_ok closed", int'(rd_ok[0]), 0);
    check("R4 wr_ok closed", int'(wr_ok[0]), 0);
    gap_check(0, 0, 5, 1, "R4 act_ok");

    // R5 second precharge restarts recovery
    do_reset();
    issue(5, 0, 0, "R5 first precharge");
    step();
    step();
    issue(5, 0, 0, "R5 second precharge");
    gap_check(0, 0, 5, 1, "R5 act_ok");

    // R6 auto precharge, AL3+RTP4 = 7, then RP5
    set_timing(6, 5, 3, 4, 4, 5, 12);
    do_reset();
    issue(1, 0, 0, "R8 activate");
    for (int i = 0; i < 14; i++) step();
    issue(3, 0, 0, "R6 read auto precharge");
    #1;
    check("R6 rd_ok blocked", int'(rd_ok[0]), 0);
    check("R6 pre_ok blocked", int'(pre_ok[0]), 0);
    gap_check(0, 0, 12, 1, "R6 act_ok");

    // R7 active-time lockout: act at a, auto read at a+1, RAS20, RP5
    set_timing(6, 5, 0, 4, 4, 5, 20);
    do_reset();
    issue(1, 0, 0, "R8 activate");
    issue(3, 0, 0, "R7 read auto precharge");
    gap_check(0, 0, 24, 1, "R7 act_ok");

    // R9 rejected read must not reload the turnaround
    set_timing(6, 5, 0, 4, 4, 5, 12);
    do_reset();
    issue(1, 2, 0, "R8 activate");
    issue(2, 2, 0, "R9 legal read");
    issue(2, 2, 1, "R9 illegal read");
    gap_check(2, 2, 7, 2, "R9 wr_ok unchanged");
    issue(7, 2, 1, "R9 unused code");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule